// File: doc/BRIEF.md
# Dual-Format Serial Audio Output Formatter

This block sits behind a digital audio interface decoder. It turns decoded stereo sample pairs into a three-wire serial stream: a bit clock, a left/right word clock and a data line. A single master clock at 256 times the sample rate drives it. The block derives the bit clock and the word clock from that master clock. A frame is 64 bit clocks long: a 32-bit left slot followed by a 32-bit right slot.

The decoder hands over a new left/right pair with a one-cycle strobe. The pair comes with one error flag and one validity flag. When the error flag is set, the pair is not taken. The last good pair is sent again and the error output is raised for that frame, which hides the corrupted sample from the listener. A static format input selects one of two word layouts. One is a 20-bit word sent least significant bit first and right-justified in its slot. The other is a 16-bit word made from the top 16 sample bits, sent most significant bit first from the start of the slot. The block reads the format input only at the start of a frame.

Top module: `afmt_serial_out`

## Requirements
- R1: `bclk_o` has a period of 4 master clocks at 50% duty. Every frame has 64 bit-clock rising edges, with `lrck_o` high (left slot) for the first 32 and low (right slot) for the last 32.
- R2: `lrck_o` and `sdata_o` change only in the cycle where `bclk_o` falls, so they are stable at every rising edge of `bclk_o`.
- R3: With the format latched high, slot positions 12..31 carry sample bits 0..19 in that order. Bit 0 is at position 12 and bit 19 at position 31. Positions 0..11 are low.
- R4: With the format latched low, slot positions 0..15 carry sample bits 19 down to 4, and positions 16..31 are low.
- R5: `fmt_wide_i` is sampled once per frame, at the start of the left slot. A change during a frame does not alter that frame.
- R6: A pair captured by `pair_stb_i` during one frame is sent in the next frame, the left sample in the left slot. With no new strobe, the last pair repeats.
- R7: A strobe with `pair_err_i` high leaves the held pair unchanged. The next frame repeats the last good pair with `err_o` high. `err_o` drops in the frame after the next error-free strobe.
- R8: `vflag_o` carries `pair_vld_i` of the captured pair for the whole frame that carries it. `err_o` and `vflag_o` change only when `lrck_o` rises.
- R9: During reset `sdata_o`, `lrck_o`, `err_o` and `vflag_o` are low. The first frames after reset carry zero samples with `err_o` and `vflag_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_wide_i | input | 1 | 1: 20-bit LSB-first layout, 0: 16-bit MSB-first layout |
| pair_stb_i | input | 1 | One-cycle strobe capturing a new pair |
| left_i | input | 20 | Left sample |
| right_i | input | 20 | Right sample |
| pair_err_i | input | 1 | Pair is corrupt, keep the previous pair |
| pair_vld_i | input | 1 | Validity flag for the pair |
| bclk_o | output | 1 | Bit clock, master / 4 |
| lrck_o | output | 1 | Word clock, high in the left slot |
| sdata_o | output | 1 | Serial data, changes on falling bit clock |
| err_o | output | 1 | Current frame repeats a held pair due to an error |
| vflag_o | output | 1 | Validity flag of the current frame's pair |

## Verification
The hardest case to reach is a format change that lands inside a frame whose content was already latched under the other format. The stimulus waits until the bench's own monitor sees a new left slot begin, and only then flips the format input. It then expects the old layout for that frame and the new one for the frame after. A second hard case is a corrupt pair before any good pair has been captured, which must bring out the reset zeros with the error flag up. Directed steps cover this and back-to-back errors. Seeded random pairs, flags and formats fill in the rest, and some frames are left without a strobe to observe the repeat.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
  parameter int unsigned SMP_W     = 20;
  parameter int unsigned NARROW_W  = 16;
  parameter int unsigned SLOT_BITS = 32;
  parameter int unsigned DIV_LOG2  = 2;

  typedef struct packed {
    logic err;
    logic vld;
    logic wide;
  } afmt_flags_t;
endpackage

// File: rtl/afmt_timing.sv
module afmt_timing #(
  parameter int unsigned DIV_LOG2  = afmt_pkg::DIV_LOG2,
  parameter int unsigned SLOT_BITS = afmt_pkg::SLOT_BITS,
  parameter int unsigned CNT_W     = DIV_LOG2 + $clog2(SLOT_BITS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);
  logic [CNT_W-1:0] cnt_q;

  // starts at last count so the first frame begins right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign frame_end_o = &cnt_q;
endmodule

// File: rtl/afmt_conceal.sv
module afmt_conceal #(
  parameter int unsigned SMP_W = afmt_pkg::SMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stb_i,
  input  logic [SMP_W-1:0]      left_i,
  input  logic [SMP_W-1:0]      right_i,
  input  logic                  err_i,
  input  logic                  vld_i,
  input  logic                  wide_i,
  input  logic                  frame_end_i,
  output logic [SMP_W-1:0]      frm_left_o,
  output logic [SMP_W-1:0]      frm_right_o,
  output afmt_pkg::afmt_flags_t frm_flags_o
);
  logic [SMP_W-1:0] pend_l_q, pend_r_q;
  logic             pend_err_q, pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q   <= '0;
      pend_r_q   <= '0;
      pend_err_q <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (stb_i) begin
      if (!err_i) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
      end
      pend_err_q <= err_i;
      pend_vld_q <= vld_i;
    end
  end

  // frame latch: data, flags and format fixed for a whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_left_o  <= '0;
      frm_right_o <= '0;
      frm_flags_o <= '0;
    end else if (frame_end_i) begin
      frm_left_o       <= pend_l_q;
      frm_right_o      <= pend_r_q;
      frm_flags_o.err  <= pend_err_q;
      frm_flags_o.vld  <= pend_vld_q;
      frm_flags_o.wide <= wide_i;
    end
  end
endmodule

// File: rtl/afmt_serializer.sv
module afmt_serializer #(
  parameter int unsigned SMP_W     = afmt_pkg::SMP_W,
  parameter int unsigned NARROW_W  = afmt_pkg::NARROW_W,
  parameter int unsigned SLOT_BITS = afmt_pkg::SLOT_BITS,
  parameter int unsigned DIV_LOG2  = afmt_pkg::DIV_LOG2,
  parameter int unsigned CNT_W     = DIV_LOG2 + $clog2(SLOT_BITS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [SMP_W-1:0]      frm_left_i,
  input  logic [SMP_W-1:0]      frm_right_i,
  input  afmt_pkg::afmt_flags_t frm_flags_i,
  output logic                  bclk_o,
  output logic                  lrck_o,
  output logic                  sdata_o,
  output logic                  err_o,
  output logic                  vflag_o
);
  localparam int unsigned SLOT_LOG2 = $clog2(SLOT_BITS);
  localparam int unsigned IDX_W     = $clog2(SMP_W);
  localparam int unsigned WIDE_OFS  = SLOT_BITS - SMP_W;
  localparam int unsigned NARR_TOP  = SMP_W - 1;

  logic [SLOT_LOG2-1:0] pos;
  logic                 in_right;
  logic [SMP_W-1:0]     word_a [2];
  logic [1:0]           bit_sel;

  assign pos       = cnt_i[DIV_LOG2 +: SLOT_LOG2];
  assign in_right  = cnt_i[CNT_W-1];
  assign word_a[0] = frm_left_i;
  assign word_a[1] = frm_right_i;

  function automatic logic pick_bit(input logic [SMP_W-1:0] w,
                                    input logic [SLOT_LOG2-1:0] p,
                                    input logic wide);
    int unsigned pi;
    pi = int'(p);
    if (wide) return (pi >= WIDE_OFS) ? w[IDX_W'(pi - WIDE_OFS)] : 1'b0;
    else      return (pi < NARROW_W)  ? w[IDX_W'(NARR_TOP - pi)] : 1'b0;
  endfunction

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    assign bit_sel[ch] = pick_bit(word_a[ch], pos, frm_flags_i.wide);
  end

  // registered outputs, one cycle behind the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_o  <= 1'b1;
      lrck_o  <= 1'b0;
      sdata_o <= 1'b0;
      err_o   <= 1'b0;
      vflag_o <= 1'b0;
    end else begin
      bclk_o  <= cnt_i[DIV_LOG2-1];
      lrck_o  <= ~in_right;
      sdata_o <= in_right ? bit_sel[1] : bit_sel[0];
      err_o   <= frm_flags_i.err;
      vflag_o <= frm_flags_i.vld;
    end
  end
endmodule

// File: rtl/afmt_serial_out.sv
module afmt_serial_out #(
  parameter int unsigned SMP_W     = afmt_pkg::SMP_W,
  parameter int unsigned NARROW_W  = afmt_pkg::NARROW_W,
  parameter int unsigned SLOT_BITS = afmt_pkg::SLOT_BITS,
  parameter int unsigned DIV_LOG2  = afmt_pkg::DIV_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_wide_i,
  input  logic             pair_stb_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             pair_err_i,
  input  logic             pair_vld_i,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             sdata_o,
  output logic             err_o,
  output logic             vflag_o
);
  localparam int unsigned CNT_W = DIV_LOG2 + $clog2(SLOT_BITS) + 1;

  logic [CNT_W-1:0]      cnt;
  logic                  frame_end;
  logic [SMP_W-1:0]      frm_l, frm_r;
  afmt_pkg::afmt_flags_t frm_flags;

  afmt_timing #(.DIV_LOG2(DIV_LOG2), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_timing (
    .clk_i, .rst_ni, .cnt_o(cnt), .frame_end_o(frame_end)
  );

  afmt_conceal #(.SMP_W(SMP_W)) u_conceal (
    .clk_i, .rst_ni,
    .stb_i(pair_stb_i), .left_i, .right_i,
    .err_i(pair_err_i), .vld_i(pair_vld_i), .wide_i(fmt_wide_i),
    .frame_end_i(frame_end),
    .frm_left_o(frm_l), .frm_right_o(frm_r), .frm_flags_o(frm_flags)
  );

  afmt_serializer #(.SMP_W(SMP_W), .NARROW_W(NARROW_W), .SLOT_BITS(SLOT_BITS),
                    .DIV_LOG2(DIV_LOG2), .CNT_W(CNT_W)) u_ser (
    .clk_i, .rst_ni, .cnt_i(cnt),
    .frm_left_i(frm_l), .frm_right_i(frm_r), .frm_flags_i(frm_flags),
    .bclk_o, .lrck_o, .sdata_o, .err_o, .vflag_o
  );
endmodule

// File: rtl/afmt_serial_out_chk.sv
module afmt_serial_out_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_o,
  input logic lrck_o,
  input logic sdata_o,
  input logic err_o,
  input logic vflag_o
);
  AST_BCLK_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |=> bclk_o); // R1
  AST_BCLK_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |=> !bclk_o); // R1
  AST_LRCK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_o != $past(lrck_o)) |-> $fell(bclk_o)); // R2
  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_o != $past(sdata_o)) |-> $fell(bclk_o)); // R2
  AST_ERR_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != $past(err_o)) |-> $rose(lrck_o)); // R7
  AST_VFLAG_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vflag_o != $past(vflag_o)) |-> $rose(lrck_o)); // R8
endmodule

bind afmt_serial_out afmt_serial_out_chk u_chk (.*);

// File: tb/afmt_serial_out_tb_top.sv
module afmt_serial_out_tb_top;
  localparam time CYC = 20ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fmt_wide_i = 1'b1, pair_stb_i = 1'b0, pair_err_i = 1'b0, pair_vld_i = 1'b0;
  logic [19:0] left_i = '0, right_i = '0;
  logic bclk_o, lrck_o, sdata_o, err_o, vflag_o;

  always #(CYC/2) clk_i = ~clk_i;

  afmt_serial_out dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected 32-bit slot, position 0 at bit 31
  function automatic logic [31:0] exp_slot(input logic [19:0] w, input logic wide);
    logic [31:0] s = '0;
    for (int p = 0; p < 32; p++) begin
      if (wide) s[31-p] = (p >= 12) ? w[p-12] : 1'b0;
      else      s[31-p] = (p < 16) ? w[19-p] : 1'b0;
    end
    return s;
  endfunction

  // port monitor
  logic pb = 1, pl = 0, pd = 0, pe = 0, pv = 0, prl = 0;
  int since_rise = 0, bit_idx = -1, hi_cnt = 0;
  bit seen_rise = 0;
  int r1_bad = 0, r2_bad = 0, r8_bad = 0;
  int start_cnt = 0, frame_cnt = 0;
  logic [63:0] cur, fr_bits;
  logic cur_e, cur_v, fr_err, fr_v;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (bclk_o && !pb) begin
        if (seen_rise && since_rise != 4) r1_bad++;
        seen_rise = 1;
        since_rise = 1;
        if (lrck_o && !prl) begin
          bit_idx = 0; cur_e = err_o; cur_v = vflag_o; hi_cnt = 0; start_cnt++;
        end
        if (bit_idx >= 0) begin
          cur[63-bit_idx] = sdata_o;
          hi_cnt += int'(lrck_o);
          bit_idx++;
          if (bit_idx == 64) begin
            fr_bits = cur; fr_err = cur_e; fr_v = cur_v;
            chk(hi_cnt == 32, "R1 left-slot bits", 64'(hi_cnt), 64'd32);
            frame_cnt++;
            bit_idx = -1;
          end
        end
        prl = lrck_o;
      end else since_rise++;
      if ((lrck_o != pl || sdata_o != pd) && !(pb && !bclk_o)) r2_bad++;
      if ((err_o != pe || vflag_o != pv) && !(lrck_o && !pl)) r8_bad++;
    end
    pb = bclk_o; pl = lrck_o; pd = sdata_o; pe = err_o; pv = vflag_o;
  end

  logic [19:0] m_l = '0, m_r = '0;
  logic m_e = 0, m_v = 0;

  task automatic check_frame(input logic wide, input string tag);
    chk(fr_bits[63:32] == exp_slot(m_l, wide), {tag, " left"},  64'(fr_bits[63:32]), 64'(exp_slot(m_l, wide)));
    chk(fr_bits[31:0]  == exp_slot(m_r, wide), {tag, " right"}, 64'(fr_bits[31:0]),  64'(exp_slot(m_r, wide)));
    chk(fr_err == m_e, {tag, " R7 err"},  64'(fr_err), 64'(m_e));
    chk(fr_v == m_v,   {tag, " R8 vflag"}, 64'(fr_v),  64'(m_v));
  endtask

  task automatic send(input logic [19:0] l, input logic [19:0] r, input logic e,
                      input logic v, input logic wide, input bit flip, input bit rpt);
    int sc, fc;
    string tag;
    tag = wide ? "R3" : "R4";
    if (e) tag = {tag, " R7"};
    if (flip) tag = {tag, " R5"};
    sc = start_cnt;
    wait (start_cnt != sc);
    repeat (8) @(negedge clk_i);
    fmt_wide_i = wide;
    left_i = l; right_i = r; pair_err_i = e; pair_vld_i = v; pair_stb_i = 1'b1;
    fc = frame_cnt;
    @(negedge clk_i);
    pair_stb_i = 1'b0;
    if (!e) begin m_l = l; m_r = r; end
    m_e = e; m_v = v;
    if (flip) begin
      wait (frame_cnt == fc + 1);
      sc = start_cnt;
      wait (start_cnt != sc);
      repeat (20) @(negedge clk_i);
      fmt_wide_i = ~wide;
    end
    wait (frame_cnt == fc + 2);
    check_frame(wide, {tag, " R6"});
    if (rpt) begin
      wait (frame_cnt == fc + 3);
      check_frame(fmt_wide_i, "R6 repeat");
    end
  endtask

  task automatic finish_run();
    chk(r1_bad == 0, "R1 bclk period", 64'(r1_bad), 64'd0);
    chk(r2_bad == 0, "R2 change off falling edge", 64'(r2_bad), 64'd0);
    chk(r8_bad == 0, "R8 flag change off frame start", 64'(r8_bad), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    int fc;
    void'($urandom(32'h5eed_a11f));
    repeat (5) @(negedge clk_i);
    chk(sdata_o == 0 && lrck_o == 0, "R9 reset lines", {62'd0, sdata_o, lrck_o}, 64'd0);
    chk(err_o == 0 && vflag_o == 0, "R9 reset flags", {62'd0, err_o, vflag_o}, 64'd0);
    rst_ni = 1'b1;
    fc = frame_cnt;
    wait (frame_cnt == fc + 1);
    check_frame(1'b1, "R9 first frame");
    // corrupt pair before any good one: zeros held, err up
    send(20'hABCDE, 20'h12345, 1'b1, 1'b1, 1'b1, 0, 0);
    send(20'hFFFFF, 20'h00001, 1'b0, 1'b1, 1'b1, 0, 1);
    send(20'h80000, 20'h7FFFF, 1'b0, 1'b0, 1'b0, 0, 1);
    send(20'h5A5A5, 20'hA5A5A, 1'b1, 1'b0, 1'b0, 0, 0);
    send(20'h11111, 20'h22222, 1'b1, 1'b1, 1'b0, 0, 1);
    send(20'h0F0F0, 20'hF0F0F, 1'b0, 1'b1, 1'b0, 1, 1);
    send(20'h3C3C3, 20'hC3C3C, 1'b0, 1'b0, 1'b1, 1, 1);
    for (int i = 0; i < 26; i++) begin
      send(20'($urandom), 20'($urandom), ($urandom % 5) == 0, 1'($urandom),
           1'($urandom), ($urandom % 4) == 0, (i % 4) == 0);
    end
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end
endmodule